// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block runs one external memory cycle at a time on a multiplexed address/data bus. The low address byte and the data byte share one 8-bit port. The high address byte has its own 8-bit port. A requester presents a 16-bit address, a read/write flag, a width flag (8-bit cycle or 16-bit wide cycle), a write byte and a speed flag (standard or double speed). The sequencer then drives an address latch enable, active-low read and write strobes and both ports through a fixed series of phases. When the cycle ends it pulses `done`; for reads, the captured low byte is then on `rdata`.

All phase lengths are counted on `osc_tick`. This clock enable marks half an oscillator period, so standard-mode lengths are even tick counts, and double-speed mode uses exactly half of each. In a wide cycle the high port carries the upper data byte. On a write that byte comes from a high-byte register, which is loaded through `hi_load`. On a read, the byte sampled from the high port is stored in that register.

The state machine has these states: `ST_IDLE`, `ST_LATCH` (latch enable high), `ST_AHOLD` (address hold), `ST_SETUP` (data setup), `ST_STROBE` (read or write strobe low) and `ST_TAIL` (strobe released). `ST_IDLE` goes to `ST_LATCH` when a request is accepted. Each later state moves to the next one on the tick that ends its length, and `ST_TAIL` returns to `ST_IDLE`. There is no other transition.

Top module: `ebus_seq`

## Requirements
- R1: `req_ready` is 1 exactly when the sequencer is idle, and a request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. A `req_valid` pulse during a cycle has no effect on that cycle's outputs, and it does not start another cycle.
- R2: In standard mode `ale` is high for 4 ticks (2 oscillator periods), starting the cycle after acceptance. The low address byte is on `ad_out` (with `ad_oe`=1) and the high address byte is on `ah_out`, from the first cycle of that pulse until 1 oscillator period after `ale` falls.
- R3: In standard mode the strobe goes low 6 ticks after `ale` falls and stays low for 12 ticks. `rd_n` is the strobe on reads and `wr_n` on writes, and the two are never low together.
- R4: The cycle ends 2 ticks (1 period) after the strobe rises. In the clock after the final tick, `done` is 1 for exactly one clock and `req_ready` returns to 1, with `ale`=0 and both ports undriven.
- R5: On a write, `wdata` is driven on `ad_out` from 1 period after `ale` falls until the end of the cycle. This covers 8 periods before `wr_n` rises and 1 period after it.
- R6: When `req_x2`=1, every phase length is half its standard value (2, 1, 2, 6 and 1 ticks).
- R7: On a read, `ad_oe` is 0 from the clock where `rd_n` falls until the cycle ends. `rdata` takes the `ad_in` value present in the final oscillator period before `rd_n` rises (last 2 ticks, or the last tick in double-speed mode).
- R8: In an 8-bit cycle (`req_wide`=0), `ah_out` drives the high address byte with `ah_oe`=1 in every phase, and `hi_data` is not changed.
- R9: In a wide cycle, a write drives `hi_data` on `ah_out` from the data setup phase to the end of the cycle. A read releases `ah_oe` while the strobe is low and through the tail, and stores the `ah_in` value sampled at the same point as R7 into `hi_data`.
- R10: `hi_load`=1 copies `hi_load_data` into `hi_data` on the next clock edge.
- R11: After reset, `ale`=0, `rd_n`=`wr_n`=1, `ad_oe`=`ah_oe`=0, `done`=0, `req_ready`=1 and `rdata`=`hi_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | Clock enable, one pulse per half oscillator period |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 16 | Cycle address |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_wide | input | 1 | 1 = 16-bit wide cycle |
| req_x2 | input | 1 | 1 = double-speed phase lengths |
| req_wdata | input | 8 | Low data byte for writes |
| hi_load | input | 1 | Load the high-byte register |
| hi_load_data | input | 8 | Value for the high-byte register |
| hi_data | output | 8 | High-byte register contents |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 8 | Low address/data port, output value |
| ad_oe | output | 1 | Low port output enable |
| ad_in | input | 8 | Low port, input value |
| ah_out | output | 8 | High address port, output value |
| ah_oe | output | 1 | High port output enable |
| ah_in | input | 8 | High port, input value |
| rdata | output | 8 | Low byte captured by the last read |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The assertions assume that `req_valid` is only raised for one clock while `req_ready` is 1, and that the request fields and `hi_data` stay unchanged for the whole cycle. The bench drops `req_valid` one clock after acceptance and keeps every field stable until `done`. It does not use `hi_load` while a cycle is running. When it deliberately raises `req_valid` during a busy cycle, it changes only the request fields, and those are ignored.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LATCH  = 3'd1,
        ST_AHOLD  = 3'd2,
        ST_SETUP  = 3'd3,
        ST_STROBE = 3'd4,
        ST_TAIL   = 3'd5
    } bus_state_e;

endpackage

// File: rtl/ebus_phase_timer.sv
module ebus_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = tick && (cnt_q == '0);

endmodule

// File: rtl/ebus_seq_fsm.sv
module ebus_seq_fsm
    import ebus_pkg::*;
#(
    parameter int T_LATCH  = 4,
    parameter int T_AHOLD  = 2,
    parameter int T_SETUP  = 4,
    parameter int T_STROBE = 12,
    parameter int T_TAIL   = 2,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_x2,
    input  logic             cur_x2,
    input  logic             expire,
    output bus_state_e       state,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             capture,
    output logic             done
);

    bus_state_e state_q;
    bus_state_e state_nx;
    logic       len_x2;

    function automatic int phase_len(input bus_state_e st, input logic x2);
        int t;
        unique case (st)
            ST_LATCH:  t = T_LATCH;
            ST_AHOLD:  t = T_AHOLD;
            ST_SETUP:  t = T_SETUP;
            ST_STROBE: t = T_STROBE;
            ST_TAIL:   t = T_TAIL;
            default:   t = 1;
        endcase
        if (x2 && (st != ST_IDLE)) begin
            t = t / 2;
        end
        return t;
    endfunction

    // next-state decode
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_nx = ST_LATCH;
            ST_LATCH:  if (expire)    state_nx = ST_AHOLD;
            ST_AHOLD:  if (expire)    state_nx = ST_SETUP;
            ST_SETUP:  if (expire)    state_nx = ST_STROBE;
            ST_STROBE: if (expire)    state_nx = ST_TAIL;
            ST_TAIL:   if (expire)    state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // end-of-cycle pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (state_q == ST_TAIL) && expire;
        end
    end

    // control outputs
    always_comb begin
        accept   = (state_q == ST_IDLE) && req_valid;
        tmr_load = accept || ((state_q != ST_IDLE) && expire);
        len_x2   = accept ? req_x2 : cur_x2;
        tmr_val  = CNT_W'(phase_len(state_nx, len_x2) - 1);
        capture  = (state_q == ST_STROBE) && expire;
    end

    assign state = state_q;

endmodule

// File: rtl/ebus_seq_datapath.sv
module ebus_seq_datapath
    import ebus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_e        state,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic              req_x2,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic              hi_load,
    input  logic [BYTE_W-1:0] hi_load_data,
    input  logic [BYTE_W-1:0] ad_in,
    input  logic [BYTE_W-1:0] ah_in,
    output logic              cur_x2,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [BYTE_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [BYTE_W-1:0] ah_out,
    output logic              ah_oe,
    output logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] hi_data
);

    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic              wide_q;
    logic              x2_q;
    logic [BYTE_W-1:0] wdata_q;
    logic [BYTE_W-1:0] rdata_q;
    logic [BYTE_W-1:0] hi_q;
    logic [BYTE_W-1:0] addr_lo;
    logic [BYTE_W-1:0] addr_hi;
    logic [BYTE_W-1:0] ah_data;

    // request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            wide_q  <= 1'b0;
            x2_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            wide_q  <= req_wide;
            x2_q    <= req_x2;
            wdata_q <= req_wdata;
        end
    end

    // read capture and high-byte register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            hi_q    <= '0;
        end else begin
            if (capture && !write_q) begin
                rdata_q <= ad_in;
            end
            if (capture && !write_q && wide_q) begin
                hi_q <= ah_in;
            end else if (hi_load) begin
                hi_q <= hi_load_data;
            end
        end
    end

    assign addr_lo = addr_q[BYTE_W-1:0];
    assign addr_hi = addr_q[ADDR_W-1:BYTE_W];
    assign ah_data = (write_q && wide_q) ? hi_q : addr_hi;

    // pin outputs per state
    always_comb begin
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        ad_oe  = 1'b0;
        ad_out = '0;
        ah_oe  = 1'b0;
        ah_out = '0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_LATCH: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = addr_lo;
                ah_oe  = 1'b1;
                ah_out = addr_hi;
            end
            ST_AHOLD: begin
                ad_oe  = 1'b1;
                ad_out = addr_lo;
                ah_oe  = 1'b1;
                ah_out = addr_hi;
            end
            ST_SETUP: begin
                ad_oe  = 1'b1;
                ad_out = write_q ? wdata_q : addr_lo;
                ah_oe  = 1'b1;
                ah_out = ah_data;
            end
            ST_STROBE: begin
                rd_n   = write_q;
                wr_n   = !write_q;
                ad_oe  = write_q;
                ad_out = write_q ? wdata_q : '0;
                ah_oe  = !(wide_q && !write_q);
                ah_out = ah_data;
            end
            ST_TAIL: begin
                ad_oe  = write_q;
                ad_out = write_q ? wdata_q : '0;
                ah_oe  = !(wide_q && !write_q);
                ah_out = ah_data;
            end
            default: begin
            end
        endcase
    end

    assign cur_x2  = x2_q;
    assign rdata   = rdata_q;
    assign hi_data = hi_q;

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
    import ebus_pkg::*;
#(
    parameter int T_LATCH  = 4,
    parameter int T_AHOLD  = 2,
    parameter int T_SETUP  = 4,
    parameter int T_STROBE = 12,
    parameter int T_TAIL   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_addr,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic              req_x2,
    input  logic [7:0]        req_wdata,
    input  logic              hi_load,
    input  logic [7:0]        hi_load_data,
    output logic [7:0]        hi_data,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [7:0]        ad_out,
    output logic              ad_oe,
    input  logic [7:0]        ad_in,
    output logic [7:0]        ah_out,
    output logic              ah_oe,
    input  logic [7:0]        ah_in,
    output logic [7:0]        rdata,
    output logic              done
);

    localparam int T_MAX = (T_STROBE > T_LATCH) ? T_STROBE : T_LATCH;
    localparam int CNT_W = $clog2(T_MAX + 1);

    bus_state_e       state;
    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             capture;
    logic             expire;
    logic             cur_x2;

    ebus_phase_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (osc_tick),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (expire)
    );

    ebus_seq_fsm #(
        .T_LATCH  (T_LATCH),
        .T_AHOLD  (T_AHOLD),
        .T_SETUP  (T_SETUP),
        .T_STROBE (T_STROBE),
        .T_TAIL   (T_TAIL),
        .CNT_W    (CNT_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_x2    (req_x2),
        .cur_x2    (cur_x2),
        .expire    (expire),
        .state     (state),
        .accept    (accept),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .capture   (capture),
        .done      (done)
    );

    ebus_seq_datapath dp_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .state        (state),
        .accept       (accept),
        .capture      (capture),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .req_wide     (req_wide),
        .req_x2       (req_x2),
        .req_wdata    (req_wdata),
        .hi_load      (hi_load),
        .hi_load_data (hi_load_data),
        .ad_in        (ad_in),
        .ah_in        (ah_in),
        .cur_x2       (cur_x2),
        .ale          (ale),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .ad_out       (ad_out),
        .ad_oe        (ad_oe),
        .ah_out       (ah_out),
        .ah_oe        (ah_oe),
        .rdata        (rdata),
        .hi_data      (hi_data)
    );

    assign req_ready = (state == ST_IDLE);

endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic ad_oe,
    input logic done
);

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    a_r2_ale_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));

    a_r7_read_releases_port: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    a_r5_write_drives_port: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    a_r1_start_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> $past(req_valid && req_ready));

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !ale && rd_n && wr_n && !ad_oe));

    a_r1_busy_while_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n || ale) |-> !req_ready);

endmodule

bind ebus_seq ebus_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ad_oe     (ad_oe),
    .done      (done)
);

// File: tb/ebus_seq_tb_top.sv
module ebus_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic        req_x2 = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        hi_load = 1'b0;
    logic [7:0]  hi_load_data = '0;
    logic [7:0]  hi_data;
    logic        ale, rd_n, wr_n, ad_oe, ah_oe, done;
    logic [7:0]  ad_out, ah_out, rdata;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ah_in = '0;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   finished = 0;
    logic [7:0] m_hi = '0;

    always #5 clk = ~clk;

    ebus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wide(req_wide), .req_x2(req_x2),
        .req_wdata(req_wdata), .hi_load(hi_load), .hi_load_data(hi_load_data),
        .hi_data(hi_data), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ah_out(ah_out),
        .ah_oe(ah_oe), .ah_in(ah_in), .rdata(rdata), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // cumulative phase boundaries in ticks, taken from the requirements
    function automatic int bound(input int i, input bit x2);
        int s [5] = '{4, 6, 10, 22, 24};
        return x2 ? s[i] / 2 : s[i];
    endfunction

    function automatic int phase_of(input int k, input bit x2);
        for (int i = 0; i < 5; i++) begin
            if (k < bound(i, x2)) return i + 1;
        end
        return 0;
    endfunction

    task automatic run_cycle(input logic [15:0] a, input bit w, input bit wd,
                             input bit x2, input logic [7:0] d,
                             input int tick_pct, input bit poke);
        int k = 0;
        int guard = 0;
        int ph;
        int last_per;
        logic [7:0] lo_early, hi_early;
        logic [7:0] exp_ah;
        string t_ale, t_ah;
        lo_early = 8'($urandom);
        hi_early = 8'($urandom);
        last_per = bound(3, x2) - (x2 ? 1 : 2);
        t_ale = x2 ? "R6" : "R2";
        t_ah  = wd ? "R9" : "R8";
        @(negedge clk);
        osc_tick  = 1'b0;
        req_addr  = a;
        req_write = w;
        req_wide  = wd;
        req_x2    = x2;
        req_wdata = d;
        req_valid = 1'b1;
        chk(req_ready === 1'b1, "R1", "ready before request", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        while (1) begin
            ph = phase_of(k, x2);
            if (k == bound(4, x2)) begin
                chk(done === 1'b1, "R4", "done at cycle end", done, 1);
                chk(req_ready === 1'b1, "R4", "ready at cycle end", req_ready, 1);
                break;
            end
            chk(done === 1'b0, "R4", "done during cycle", done, 0);
            chk(req_ready === 1'b0, "R1", "ready during cycle", req_ready, 0);
            chk(ale === (ph == 1), t_ale, "ale", ale, ph == 1);
            chk(rd_n === !(ph == 4 && !w), x2 ? "R6" : "R3", "rd_n", rd_n, !(ph == 4 && !w));
            chk(wr_n === !(ph == 4 && w), x2 ? "R6" : "R3", "wr_n", wr_n, !(ph == 4 && w));
            if (ph <= 2 || (ph == 3 && !w)) begin
                chk(ad_oe === 1'b1 && ad_out === a[7:0], "R2", "low address", ad_out, a[7:0]);
            end else if (w) begin
                chk(ad_oe === 1'b1 && ad_out === d, "R5", "write data", ad_out, d);
            end else begin
                chk(ad_oe === 1'b0, "R7", "low port released", ad_oe, 0);
            end
            if (wd && !w && ph >= 4) begin
                chk(ah_oe === 1'b0, "R9", "high port released", ah_oe, 0);
            end else begin
                exp_ah = (wd && w && ph >= 3) ? m_hi : a[15:8];
                chk(ah_oe === 1'b1 && ah_out === exp_ah, ph <= 2 ? "R2" : t_ah,
                    "high port", ah_out, exp_ah);
            end
            if (poke) begin
                if (k == 7) begin
                    req_valid = 1'b1;
                    req_addr  = ~a;
                    req_wdata = ~d;
                    req_write = !w;
                end else if (k >= 9) begin
                    req_valid = 1'b0;
                    req_addr  = a;
                    req_wdata = d;
                    req_write = w;
                end
            end
            ad_in = (k >= last_per) ? ~lo_early : lo_early;
            ah_in = (k >= last_per) ? ~hi_early : hi_early;
            osc_tick = (($urandom % 100) < tick_pct);
            if (osc_tick) k++;
            guard++;
            if (guard > 5000) begin
                chk(0, "R4", "cycle never ended", k, bound(4, x2));
                break;
            end
            @(negedge clk);
        end
        osc_tick  = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        chk(done === 1'b0, "R4", "done lasts one clock", done, 0);
        chk(ale === 1'b0 && ad_oe === 1'b0 && ah_oe === 1'b0, "R4", "bus idle after cycle",
            {ale, ad_oe, ah_oe}, 0);
        chk(req_ready === 1'b1, "R1", "no second cycle started", req_ready, 1);
        if (!w) begin
            chk(rdata === ~lo_early, "R7", "read data", rdata, ~lo_early);
            if (wd) m_hi = ~hi_early;
        end
        chk(hi_data === m_hi, wd ? "R9" : "R8", "high-byte register", hi_data, m_hi);
    endtask

    task automatic load_hi(input logic [7:0] v);
        @(negedge clk);
        hi_load = 1'b1;
        hi_load_data = v;
        @(negedge clk);
        hi_load = 1'b0;
        m_hi = v;
        chk(hi_data === v, "R10", "high-byte load", hi_data, v);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(ale === 1'b0 && rd_n === 1'b1 && wr_n === 1'b1, "R11", "strobes in reset",
            {ale, rd_n, wr_n}, 3'b011);
        chk(ad_oe === 1'b0 && ah_oe === 1'b0 && done === 1'b0 && req_ready === 1'b1, "R11",
            "ports in reset", {ad_oe, ah_oe, done, req_ready}, 4'b0001);
        chk(rdata === 8'h00 && hi_data === 8'h00, "R11", "registers in reset",
            {rdata, hi_data}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && ale === 1'b0, "R11", "idle after reset", {req_ready, ale}, 2'b10);

        // directed corner cases
        run_cycle(16'hA55A, 1'b0, 1'b0, 1'b0, 8'h00, 100, 1'b0);
        run_cycle(16'h1234, 1'b1, 1'b0, 1'b0, 8'hC3, 100, 1'b0);
        load_hi(8'h9E);
        run_cycle(16'hBEEF, 1'b1, 1'b1, 1'b1, 8'h71, 100, 1'b0);
        run_cycle(16'h0F0F, 1'b0, 1'b1, 1'b1, 8'h00, 100, 1'b0);
        run_cycle(16'hFFFF, 1'b1, 1'b0, 1'b0, 8'hFF, 50, 1'b1);
        run_cycle(16'h0001, 1'b0, 1'b1, 1'b0, 8'h00, 40, 1'b1);

        // constrained random cycles
        for (int i = 0; i < 40; i++) begin
            if (($urandom % 4) == 0) load_hi(8'($urandom));
            run_cycle(16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      8'($urandom), 30 + int'($urandom % 71), 1'($urandom));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule